// File: doc/BRIEF.md
# Oversampling UART Receive Data Recovery

This block recovers asynchronous serial frames from a single receive line. The line is first passed through a short synchronizer chain. After that it is sampled only on cycles where an external rate generator pulses `sample_tick`. Each frame has the following parts:

- one start bit;
- 5 to 9 data bits, least significant bit first;
- an optional even or odd parity bit;
- one or more stop bits.

A mode input picks between two sampling rates. In normal mode there are sixteen ticks per bit. In double-speed mode there are eight ticks per bit.

The level of every bit is decided by a 2-of-3 majority vote over three samples in the middle of the bit. This vote filters out short glitches. A start edge that fails its vote is dropped, and the receiver goes back to hunting for a low level.

Only the first stop bit is examined. As soon as its vote is complete, the receiver is ready for the next start edge. In double-speed mode it waits one extra tick first. So frames with a shortened last stop bit, or with extra stop bits, are accepted without any setting.

At the end of each frame the block presents the following, all updated together with a one-cycle strobe:

- the data word;
- a parity error flag;
- a frame error flag.

Top module: `uart_rx_recover`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `parity_err` and `frame_err` are all 0, and a line held high produces no strobe.
- R2: In normal mode (`double_speed`=0) a frame with N data bits (N = `data_bits`, 5..9, each lasting 16 ticks) is received LSB first. The data appears in `rx_data[N-1:0]`, and the upper bits are 0.
- R3: In double-speed mode (`double_speed`=1) the same frames are received with each bit lasting 8 ticks.
- R4: Each bit is decided by a majority vote over the center samples: samples 8, 9 and 10 of 16, or samples 4, 5 and 6 of 8, counted from 1 at the first low sample of the start bit. A single inverted sample inside a bit does not change the received value.
- R5: If the start bit votes high, the frame is abandoned with no strobe, and a following valid frame is received correctly.
- R6: `parity_mode` selects the parity check: 0 = none, 1 = even, 2 = odd. `parity_err` is 1 when the received parity bit does not match the parity computed over the data bits. It is always 0 when parity is off.
- R7: `frame_err` is 1 when the first stop bit votes low.
- R8: In normal mode, a start edge that appears at sample 11 or later of the first stop bit is accepted as the next frame.
- R9: In double-speed mode, the receiver ignores the sample right after the stop vote. A start edge seen at the second sample after the vote (sample 8) or later is accepted.
- R10: `rx_valid` is high for exactly one cycle per frame. The data and both error flags are updated at that same cycle and describe only that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_async | input | 1 | Asynchronous serial receive line, idles high |
| sample_tick | input | 1 | One-cycle pulse at the oversampling rate |
| double_speed | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| data_bits | input | 4 | Data bits per frame, 5..9 (clamped into this range) |
| parity_mode | input | 2 | 0 none, 1 even, 2 odd, 3 treated as none |
| rx_data | output | 9 | Last received data word, LSB aligned |
| rx_valid | output | 1 | One-cycle strobe when a frame completes |
| parity_err | output | 1 | Parity mismatch on the last frame |
| frame_err | output | 1 | First stop bit of the last frame was low |

## Verification
The hardest case to reach is the early re-arm. The next start edge has to fall in the few samples between the stop-bit vote and the nominal end of the stop bit. It must arrive late enough that the stop vote still reads high, but early enough that it lands before the nominal stop bit would have ended.

The bench drives back-to-back frames whose stop bit is cut to 10 ticks in normal mode and 7 ticks in double-speed mode. These lengths are chosen so that, whatever phase offset the synchronizer adds, the next low sample lands exactly at the earliest accepted position. Both frames must then be recovered intact.

Single-tick glitches are placed at the middle of a bit, so that they land inside the voting window.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W    = 9;
    localparam int BIT_IDX_W = 4;
    localparam int MIN_BITS  = 5;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } parity_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_GAP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_result_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic [BIT_IDX_W-1:0] clamp_bits(input logic [BIT_IDX_W-1:0] n);
        if (n < BIT_IDX_W'(MIN_BITS)) return BIT_IDX_W'(MIN_BITS);
        if (n > BIT_IDX_W'(DATA_W))   return BIT_IDX_W'(DATA_W);
        return n;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else if (i == 0) chain[i] <= din;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
    parameter int OS_NORMAL = 16,
    parameter int OS_FAST   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    input  logic double_speed,
    input  logic restart,
    input  logic run,
    output logic vote_done,
    output logic vote_val,
    output logic bit_end
);
    import uart_rx_pkg::*;

    localparam int CW = $clog2(OS_NORMAL + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] idx;
    logic [CW-1:0] last;
    logic [CW-1:0] vote_hi;
    logic [1:0]    hist;

    assign idx     = cnt + 1'b1;
    assign last    = double_speed ? CW'(OS_FAST) : CW'(OS_NORMAL);
    assign vote_hi = double_speed ? CW'(OS_FAST / 2 + 2) : CW'(OS_NORMAL / 2 + 2);

    assign vote_done = run && tick && (idx == vote_hi);
    assign bit_end   = run && tick && (idx == last);
    assign vote_val  = vote3(hist[1], hist[0], line);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            hist <= 2'b11;
        end else begin
            if (tick) hist <= {hist[0], line};
            if (restart) cnt <= CW'(1);
            else if (run && tick) cnt <= (idx == last) ? '0 : idx;
        end
    end

    assert_cnt_in_bit_R2: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < last));

    assert_vote_before_end_R4: assert property (@(posedge clk) disable iff (rst)
        vote_done |-> !bit_end);
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               tick,
    input  logic                               line,
    input  logic                               double_speed,
    input  logic [uart_rx_pkg::BIT_IDX_W-1:0]  nbits,
    input  logic [1:0]                         pmode,
    input  logic                               vote_done,
    input  logic                               vote_val,
    input  logic                               bit_end,
    output logic                               restart,
    output logic                               run,
    output logic                               valid,
    output uart_rx_pkg::rx_result_t            result
);
    import uart_rx_pkg::*;

    rx_state_e               state;
    logic [BIT_IDX_W-1:0]    bit_idx;
    logic [DATA_W-1:0]       shreg;
    logic                    par_acc;
    logic                    perr_acc;
    logic                    par_on;
    logic [BIT_IDX_W-1:0]    nb_eff;

    assign nb_eff  = clamp_bits(nbits);
    assign par_on  = (pmode == PAR_EVEN) || (pmode == PAR_ODD);
    assign restart = (state == ST_IDLE) && tick && !line;
    assign run     = (state == ST_START) || (state == ST_DATA) ||
                     (state == ST_PARITY) || (state == ST_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_idx  <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            perr_acc <= 1'b0;
            valid    <= 1'b0;
            result   <= '0;
        end else begin
            valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (restart) begin
                        state    <= ST_START;
                        bit_idx  <= '0;
                        shreg    <= '0;
                        par_acc  <= 1'b0;
                        perr_acc <= 1'b0;
                    end
                end
                ST_START: begin
                    if (vote_done && vote_val) state <= ST_IDLE;
                    else if (bit_end)          state <= ST_DATA;
                end
                ST_DATA: begin
                    if (vote_done) begin
                        shreg[bit_idx] <= vote_val;
                        par_acc        <= par_acc ^ vote_val;
                    end
                    if (bit_end) begin
                        if (bit_idx == nb_eff - 1'b1) begin
                            bit_idx <= '0;
                            state   <= par_on ? ST_PARITY : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_PARITY: begin
                    if (vote_done) perr_acc <= par_acc ^ vote_val ^ (pmode == PAR_ODD);
                    if (bit_end)   state <= ST_STOP;
                end
                ST_STOP: begin
                    if (vote_done) begin
                        valid       <= 1'b1;
                        result.data <= shreg;
                        result.perr <= par_on && perr_acc;
                        result.ferr <= !vote_val;
                        state       <= double_speed ? ST_GAP : ST_IDLE;
                    end
                end
                ST_GAP: begin
                    if (tick) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_false_start_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && vote_done && vote_val) |=> (state == ST_IDLE));

    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    assert_ferr_with_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(result.ferr) |-> valid);

    assert_perr_with_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(result.perr) |-> valid);

    assert_gap_double_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> double_speed);
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover #(
    parameter int SYNC_STAGES = 2,
    parameter int OS_NORMAL   = 16,
    parameter int OS_FAST     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_async,
    input  logic       sample_tick,
    input  logic       double_speed,
    input  logic [3:0] data_bits,
    input  logic [1:0] parity_mode,
    output logic [8:0] rx_data,
    output logic       rx_valid,
    output logic       parity_err,
    output logic       frame_err
);
    import uart_rx_pkg::*;

    logic       line_s;
    logic       restart;
    logic       run;
    logic       vote_done;
    logic       vote_val;
    logic       bit_end;
    rx_result_t result;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_async),
        .dout (line_s)
    );

    uart_rx_sampler #(.OS_NORMAL(OS_NORMAL), .OS_FAST(OS_FAST)) u_sampler (
        .clk          (clk),
        .rst          (rst),
        .tick         (sample_tick),
        .line         (line_s),
        .double_speed (double_speed),
        .restart      (restart),
        .run          (run),
        .vote_done    (vote_done),
        .vote_val     (vote_val),
        .bit_end      (bit_end)
    );

    uart_rx_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .tick         (sample_tick),
        .line         (line_s),
        .double_speed (double_speed),
        .nbits        (data_bits),
        .pmode        (parity_mode),
        .vote_done    (vote_done),
        .vote_val     (vote_val),
        .bit_end      (bit_end),
        .restart      (restart),
        .run          (run),
        .valid        (rx_valid),
        .result       (result)
    );

    assign rx_data    = result.data;
    assign parity_err = result.perr;
    assign frame_err  = result.ferr;
endmodule

// File: tb/uart_rx_recover_bench.sv
module uart_rx_recover_bench;

    localparam int TDIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       sample_tick;
    logic       double_speed = 1'b0;
    logic [3:0] data_bits = 4'd8;
    logic [1:0] parity_mode = 2'd0;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       parity_err;
    logic       frame_err;

    int tests = 0;
    int fails = 0;
    int nvalid = 0;
    logic [10:0] cap [4];
    logic prev_valid = 1'b0;
    logic [1:0] tcnt = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) tcnt <= tcnt + 1'b1;
    assign sample_tick = (tcnt == 2'd3);

    uart_rx_recover u_uart_rx_recover (
        .clk          (clk),
        .rst          (rst),
        .rx_async     (rx_line),
        .sample_tick  (sample_tick),
        .double_speed (double_speed),
        .data_bits    (data_bits),
        .parity_mode  (parity_mode),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .parity_err   (parity_err),
        .frame_err    (frame_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10: strobe width and capture of each frame result
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid && prev_valid) check("R10 strobe width", 32'd2, 32'd1);
            if (rx_valid) begin
                cap[nvalid % 4] = {rx_data, parity_err, frame_err};
                nvalid++;
            end
        end
        prev_valid = rx_valid;
    end

    task automatic drive(input logic v, input int ticks);
        rx_line = v;
        repeat (ticks * TDIV) @(negedge clk);
    endtask

    task automatic send(input int val, input int nb, input int pm, input logic stop_val,
                        input bit bad_par, input bit glitch, input int stop_ticks);
        int  os;
        logic par;
        logic b;
        os  = double_speed ? 8 : 16;
        par = 1'b0;
        drive(1'b0, os);
        for (int i = 0; i < nb; i++) begin
            b = 1'((val >> i) & 1);
            par ^= b;
            if (glitch && i == 0) begin
                drive(b, os / 2);
                drive(!b, 1);
                drive(b, os - os / 2 - 1);
            end else begin
                drive(b, os);
            end
        end
        if (pm == 1 || pm == 2) drive(par ^ (pm == 2) ^ bad_par, os);
        drive(stop_val, stop_ticks);
        rx_line = 1'b1;
    endtask

    task automatic frame(input string req, input int val, input int nb, input int pm,
                         input logic stop_val, input bit bad_par, input bit glitch,
                         input int stop_ticks, input logic exp_perr, input logic exp_ferr);
        int n0;
        logic [8:0] exp_d;
        n0 = nvalid;
        data_bits   = 4'(nb);
        parity_mode = 2'(pm);
        send(val, nb, pm, stop_val, bad_par, glitch, stop_ticks);
        drive(1'b1, 3);
        exp_d = 9'(val & ((1 << nb) - 1));
        check(req, 32'(nvalid - n0), 32'd1);
        check(req, 32'(cap[n0 % 4]), 32'({exp_d, exp_perr, exp_ferr}));
        drive(1'b1, double_speed ? 24 : 40);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int vals [3];
        int n0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset", 32'({rx_valid, rx_data, parity_err, frame_err}), 32'd0);
        drive(1'b1, 50);
        check("R1 idle no strobe", 32'(nvalid), 32'd0);

        // R2/R3/R6: sweep of widths, parity modes, speeds
        for (int ds = 0; ds < 2; ds++) begin
            double_speed = 1'(ds);
            for (int nb = 5; nb <= 9; nb++) begin
                for (int pm = 0; pm < 3; pm++) begin
                    vals[0] = 0;
                    vals[1] = 511;
                    vals[2] = (nb * 37 + pm * 91 + ds * 13) & 511;
                    for (int k = 0; k < 3; k++)
                        frame(ds ? "R3 sweep" : "R2 sweep", vals[k], nb, pm, 1'b1, 1'b0, 1'b0,
                              (k == 2) ? (ds ? 16 : 32) : (ds ? 8 : 16), 1'b0, 1'b0);
                end
            end
        end

        for (int ds = 0; ds < 2; ds++) begin
            double_speed = 1'(ds);
            // R6: parity errors, even and odd
            frame("R6 even bad", 9'h0A5, 8, 1, 1'b1, 1'b1, 1'b0, ds ? 8 : 16, 1'b1, 1'b0);
            frame("R6 odd bad", 9'h13C, 9, 2, 1'b1, 1'b1, 1'b0, ds ? 8 : 16, 1'b1, 1'b0);
            // R10: flags describe only the latest frame
            frame("R10 clear", 9'h03C, 8, 2, 1'b1, 1'b0, 1'b0, ds ? 8 : 16, 1'b0, 1'b0);
            // R7: frame error
            frame("R7 stop low", 9'h05A, 7, 0, 1'b0, 1'b0, 1'b0, ds ? 8 : 16, 1'b0, 1'b1);
            frame("R7 then good", 9'h0C3, 8, 1, 1'b1, 1'b0, 1'b0, ds ? 8 : 16, 1'b0, 1'b0);
            // R4: single-sample glitch in the voting window
            frame("R4 glitch hi", 9'h001, 8, 0, 1'b1, 1'b0, 1'b1, ds ? 8 : 16, 1'b0, 1'b0);
            frame("R4 glitch lo", 9'h0FE, 8, 1, 1'b1, 1'b0, 1'b1, ds ? 8 : 16, 1'b0, 1'b0);
            // R5: false start of three ticks
            n0 = nvalid;
            drive(1'b0, 3);
            drive(1'b1, 40);
            check("R5 no strobe", 32'(nvalid - n0), 32'd0);
            frame("R5 after glitch", 9'h096, 8, 0, 1'b1, 1'b0, 1'b0, ds ? 8 : 16, 1'b0, 1'b0);
        end

        // R8: normal mode back-to-back with stop cut to 10 ticks
        double_speed = 1'b0;
        data_bits = 4'd8;
        parity_mode = 2'd1;
        n0 = nvalid;
        send(9'h0B7, 8, 1, 1'b1, 1'b0, 1'b0, 10);
        send(9'h04D, 8, 1, 1'b1, 1'b0, 1'b0, 16);
        drive(1'b1, 20);
        check("R8 count", 32'(nvalid - n0), 32'd2);
        check("R8 first", 32'(cap[n0 % 4]), 32'({9'h0B7, 2'b00}));
        check("R8 second", 32'(cap[(n0 + 1) % 4]), 32'({9'h04D, 2'b00}));

        // R9: double speed back-to-back with stop cut to 7 ticks
        double_speed = 1'b1;
        data_bits = 4'd9;
        parity_mode = 2'd2;
        n0 = nvalid;
        send(9'h1E1, 9, 2, 1'b1, 1'b0, 1'b0, 7);
        send(9'h02E, 9, 2, 1'b1, 1'b0, 1'b0, 8);
        drive(1'b1, 20);
        check("R9 count", 32'(nvalid - n0), 32'd2);
        check("R9 first", 32'(cap[n0 % 4]), 32'({9'h1E1, 2'b00}));
        check("R9 second", 32'(cap[(n0 + 1) % 4]), 32'({9'h02E, 2'b00}));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule